// File: doc/BRIEF.md
# Byte/Word ALU with Barrel Shifter

This block is the arithmetic core of a 16-bit datapath. On each cycle where the operation strobe is high, it takes two operands, a 4-bit opcode, a byte/word select and an external carry. It then registers a 16-bit result together with four condition flags: zero, negative, carry and overflow. The supported operations are add and subtract, the carry-chained forms of both for multi-precision arithmetic, the three bitwise operations, sign extension of a byte to a word, and five shift and rotate operations. Every shift and rotate handles any count from 0 to 15 in a single cycle.

In byte mode the operation acts on the low eight bits of the operands, and the upper byte of operand A passes through unchanged. The flags are taken from bit 7, and the overflow flag from the carries around bits 6 and 7, instead of from bits 14 and 15. To build wider arithmetic, the surrounding logic feeds the registered carry flag back as the carry input of the next, more significant piece.

Top module: `bw_alu`

## Requirements
- R1: While reset is high at a clock edge, the result and all four flags clear to zero.
- R2: Opcode 0 (add) registers A+B and ignores the carry input. Opcode 1 (add with carry) registers A+B+carry_in. In both, the carry flag is the carry out of the active MSB.
- R3: Opcode 2 (subtract) registers A-B. Opcode 3 (subtract with borrow) registers A-B-carry_in, treating the carry input as a borrow. In both, the carry flag is set exactly when a borrow occurs.
- R4: For opcodes 0-3, overflow is set exactly when the signed result does not fit the active width: the carry into the active MSB differs from the carry out of it.
- R5: With byte_mode high, every opcode except 7 works on bits 7:0 only. Result bits 15:8 equal A[15:8]. Zero tests bits 7:0, negative is bit 7, carry is the carry out of bit 7, and overflow uses the carries into and out of bit 7.
- R6: Opcodes 4, 5 and 6 give A AND B, A OR B and A XOR B, with carry and overflow cleared.
- R7: Opcode 7 gives A[7:0] sign-extended to 16 bits, whatever byte_mode is. Its zero and negative flags are evaluated over all 16 bits, and carry and overflow are cleared.
- R8: Opcodes 8 (shift left), 9 (logical shift right) and 10 (arithmetic shift right) shift A over the active width by the count in B[3:0]. Vacated bits fill with zero, or with the active sign bit for opcode 10. Carry is the last bit shifted out: zero for counts beyond the width on opcodes 8 and 9, the sign for opcode 10. Overflow is cleared.
- R9: Opcodes 11 (rotate left) and 12 (rotate right) rotate A over the active width by B[3:0] modulo that width. For a non-zero count, carry is the last bit that wrapped around. Overflow is cleared.
- R10: A shift or rotate with a count of zero returns the operand unchanged and clears carry.
- R11: Result and flags hold while op_valid is low. Opcodes 13-15 are reserved: they leave result and flags unchanged even when op_valid is high.
- R12: Result and flags for an operation appear on the outputs right after the clock edge on which op_valid was sampled high, so back-to-back operations issue every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; updates result and flags |
| op_code | input | 4 | Operation select |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| carry_in | input | 1 | Carry or borrow for the chained arithmetic forms |
| opnd_a | input | 16 | First operand; shift and rotate source |
| opnd_b | input | 16 | Second operand; bits 3:0 are the shift count |
| result | output | 16 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow / last bit shifted out |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The only state is the result register and the flags register. A wrong value in either shows up at the ports one cycle after the operation that loaded it, and it stays visible until the next valid operation. The carry flag needs the most attention, because a wrong carry is invisible in the result of the operation that produced it. It only shows up in the following chained add or subtract, so the multi-word scenarios compare the whole wide sum, not just each piece. Byte-mode errors mostly appear as a flag taken from the wrong bit position, or as upper-byte corruption. The stimulus therefore uses operands whose bit 15 and bit 7 differ, and checks the upper byte on every byte operation.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

    localparam int WORD_W = 16;
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SEXT = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_ASR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_R13  = 4'd13,
        OP_R14  = 4'd14,
        OP_R15  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              carry;
        logic              ovf;
    } unit_out_t;

    function automatic logic op_is_shift(alu_op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ASR) ||
               (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBC);
    endfunction

    function automatic logic op_is_reserved(alu_op_e op);
        return (op == OP_R13) || (op == OP_R14) || (op == OP_R15);
    endfunction

    function automatic alu_flags_t make_flags(logic [WORD_W-1:0] d, logic wide,
                                              logic c, logic v);
        alu_flags_t f;
        f.z = wide ? (d == '0) : (d[HALF_W-1:0] == '0);
        f.n = wide ? d[WORD_W-1] : d[HALF_W-1];
        f.c = c;
        f.v = v;
        return f;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import bw_alu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = W / 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         byte_sel,
    input  logic         sub,
    input  logic         use_cin,
    input  logic         cin,
    output unit_out_t    out
);

    logic [W-1:0] bb;
    logic         cin_eff;
    logic [W:0]   sum_w;
    logic [W-1:0] low_w;
    logic [BW:0]  sum_b;
    logic [BW-1:0] low_b;
    logic         cout;
    logic         cmsb;

    // Subtraction is A + ~B + 1; a borrow input removes the +1.
    assign bb      = sub ? ~b : b;
    assign cin_eff = sub ? (use_cin ? ~cin : 1'b1) : (use_cin & cin);

    // Full-width sums and the sums of the bits below each MSB give
    // the carry out of and the carry into the active MSB.
    assign sum_w = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, cin_eff};
    assign low_w = {1'b0, a[W-2:0]} + {1'b0, bb[W-2:0]} + {{(W-1){1'b0}}, cin_eff};
    assign sum_b = {1'b0, a[BW-1:0]} + {1'b0, bb[BW-1:0]} + {{BW{1'b0}}, cin_eff};
    assign low_b = {1'b0, a[BW-2:0]} + {1'b0, bb[BW-2:0]} + {{(BW-1){1'b0}}, cin_eff};

    assign cout = byte_sel ? sum_b[BW] : sum_w[W];
    assign cmsb = byte_sel ? low_b[BW-1] : low_w[W-1];

    always_comb begin
        out.data  = byte_sel ? {a[W-1:BW], sum_b[BW-1:0]} : sum_w[W-1:0];
        out.carry = sub ? ~cout : cout;
        out.ovf   = cout ^ cmsb;
    end

endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
    parameter int WIDTH = 33,
    parameter int CNT_W = 4,
    parameter bit LEFT  = 1'b1
) (
    input  logic [WIDTH-1:0] din,
    input  logic [CNT_W-1:0] amt,
    input  logic             fill,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [CNT_W+1];

    assign stg[0] = din;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        if (LEFT) begin : g_left
            assign stg[k+1] = amt[k] ? {stg[k][WIDTH-1-SH:0], {SH{1'b0}}} : stg[k];
        end else begin : g_right
            assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][WIDTH-1:SH]} : stg[k];
        end
    end

    assign dout = stg[CNT_W];

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import bw_alu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = W / 2,
    parameter int CW = CNT_W
) (
    input  logic [W-1:0]  a,
    input  logic [CW-1:0] cnt,
    input  logic          byte_sel,
    input  alu_op_e       op,
    output unit_out_t     out
);

    localparam int XW = 2 * W + 1;

    logic [W-1:0]   xa;
    logic [2*W-1:0] dbl;
    logic [2*W-1:0] sx;
    logic           sgn;
    logic [CW-1:0]  rot_amt;
    logic [XW-1:0]  l_in, l_out, r_in, r_out;
    logic [CW-1:0]  l_amt, r_amt;
    logic [W-1:0]   r_act;
    logic           c_out;
    logic           cnt_nz;

    assign xa      = byte_sel ? {{(W-BW){1'b0}}, a[BW-1:0]} : a;
    assign dbl     = byte_sel ? {{W{1'b0}}, a[BW-1:0], a[BW-1:0]} : {a, a};
    assign sgn     = byte_sel ? a[BW-1] : a[W-1];
    assign sx      = byte_sel ? {{(2*W-BW){a[BW-1]}}, a[BW-1:0]} : {{W{a[W-1]}}, a};
    assign rot_amt = byte_sel ? {1'b0, cnt[CW-2:0]} : cnt;
    assign cnt_nz  = (cnt != '0);

    // Left path serves shift-left and rotate-left.
    assign l_in  = (op == OP_ROL) ? {1'b0, dbl} : {{(W+1){1'b0}}, xa};
    assign l_amt = (op == OP_ROL) ? rot_amt : cnt;

    // Right path serves both right shifts and rotate-right; a guard bit
    // below the operand catches the last bit shifted out.
    always_comb begin
        case (op)
            OP_ASR:  r_in = {sx, 1'b0};
            OP_ROR:  r_in = {1'b0, dbl};
            default: r_in = {{W{1'b0}}, xa, 1'b0};
        endcase
    end
    assign r_amt = (op == OP_ROR) ? rot_amt : cnt;

    alu_barrel #(.WIDTH(XW), .CNT_W(CW), .LEFT(1'b1)) u_left (
        .din  (l_in),
        .amt  (l_amt),
        .fill (1'b0),
        .dout (l_out)
    );

    alu_barrel #(.WIDTH(XW), .CNT_W(CW), .LEFT(1'b0)) u_right (
        .din  (r_in),
        .amt  (r_amt),
        .fill ((op == OP_ASR) ? sgn : 1'b0),
        .dout (r_out)
    );

    always_comb begin
        r_act = '0;
        c_out = 1'b0;
        case (op)
            OP_SHL: begin
                r_act = byte_sel ? {{(W-BW){1'b0}}, l_out[BW-1:0]} : l_out[W-1:0];
                c_out = byte_sel ? l_out[BW] : l_out[W];
            end
            OP_ROL: begin
                r_act = byte_sel ? {{(W-BW){1'b0}}, l_out[2*BW-1:BW]} : l_out[2*W-1:W];
                c_out = cnt_nz & r_act[0];
            end
            OP_SHR, OP_ASR: begin
                r_act = byte_sel ? {{(W-BW){1'b0}}, r_out[BW:1]} : r_out[W:1];
                c_out = r_out[0];
            end
            OP_ROR: begin
                r_act = byte_sel ? {{(W-BW){1'b0}}, r_out[BW-1:0]} : r_out[W-1:0];
                c_out = cnt_nz & (byte_sel ? r_act[BW-1] : r_act[W-1]);
            end
            default: begin
                r_act = '0;
                c_out = 1'b0;
            end
        endcase
    end

    always_comb begin
        out.data  = byte_sel ? {a[W-1:BW], r_act[BW-1:0]} : r_act;
        out.carry = c_out;
        out.ovf   = 1'b0;
    end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
    import bw_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              byte_mode,
    input  logic              carry_in,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic [WORD_W-1:0] result,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c,
    output logic              flag_v
);

    alu_op_e     op;
    unit_out_t   add_o, sft_o, nxt;
    alu_flags_t  nxt_flags, flg_q;
    logic [WORD_W-1:0] res_q;
    logic        wide_flags;
    logic        is_sub;

    assign op     = alu_op_e'(op_code);
    assign is_sub = (op == OP_SUB) || (op == OP_SUBC);

    alu_addsub #(.W(WORD_W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .byte_sel (byte_mode),
        .sub      (is_sub),
        .use_cin  ((op == OP_ADDC) || (op == OP_SUBC)),
        .cin      (carry_in),
        .out      (add_o)
    );

    alu_shift_unit #(.W(WORD_W), .CW(CNT_W)) u_shift (
        .a        (opnd_a),
        .cnt      (opnd_b[CNT_W-1:0]),
        .byte_sel (byte_mode),
        .op       (op),
        .out      (sft_o)
    );

    function automatic logic [WORD_W-1:0] merge_byte(logic [WORD_W-1:0] full,
                                                     logic [WORD_W-1:0] keep,
                                                     logic sel);
        return sel ? {keep[WORD_W-1:HALF_W], full[HALF_W-1:0]} : full;
    endfunction

    always_comb begin
        nxt = '0;
        if (op_is_arith(op)) begin
            nxt = add_o;
        end else if (op_is_shift(op)) begin
            nxt = sft_o;
        end else begin
            case (op)
                OP_AND:  nxt.data = merge_byte(opnd_a & opnd_b, opnd_a, byte_mode);
                OP_OR:   nxt.data = merge_byte(opnd_a | opnd_b, opnd_a, byte_mode);
                OP_XOR:  nxt.data = merge_byte(opnd_a ^ opnd_b, opnd_a, byte_mode);
                OP_SEXT: nxt.data = {{(WORD_W-HALF_W){opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]};
                default: nxt.data = res_q;
            endcase
        end
    end

    assign wide_flags = !byte_mode || (op == OP_SEXT);
    assign nxt_flags  = make_flags(nxt.data, wide_flags, nxt.carry, nxt.ovf);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (op_valid && !op_is_reserved(op)) begin
            res_q <= nxt.data;
            flg_q <= nxt_flags;
        end
    end

    assign result = res_q;
    assign flag_z = flg_q.z;
    assign flag_n = flg_q.n;
    assign flag_c = flg_q.c;
    assign flag_v = flg_q.v;

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code >= 4'd13) |=> ($stable(result) &&
            $stable({flag_z, flag_n, flag_c, flag_v})));

    // R6
    logic_cv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 4'd4 || op_code == 4'd5 || op_code == 4'd6))
            |=> (!flag_c && !flag_v));

    // R5
    byte_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && byte_mode && op_code != 4'd7 && op_code < 4'd13)
            |=> (result[15:8] == $past(opnd_a[15:8])));

    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 4'd8 && op_code <= 4'd12 && opnd_b[3:0] == 4'd0)
            |=> (!flag_c && result == $past(opnd_a)));

    // R7
    sext_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd7)
            |=> (result == {{8{$past(opnd_a[7])}}, $past(opnd_a[7:0])} &&
                 !flag_c && !flag_v));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result == '0 && !flag_z && !flag_n && !flag_c && !flag_v));

endmodule

// File: tb/bw_alu_bench.sv
module bw_alu_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        byte_mode = 1'b0;
    logic        carry_in = 1'b0;
    logic [15:0] opnd_a = 16'h0;
    logic [15:0] opnd_b = 16'h0;
    logic [15:0] result;
    logic        flag_z, flag_n, flag_c, flag_v;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bw_alu u_bw_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .byte_mode(byte_mode), .carry_in(carry_in), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .result(result), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    // Independent model: returns {result, z, n, c, v}.
    function automatic logic [19:0] model(int op, bit bm, bit ci,
                                          logic [15:0] a, logic [15:0] b);
        int w = bm ? 8 : 16;
        int unsigned m = bm ? 32'hFF : 32'hFFFF;
        int unsigned ua = a & m;
        int unsigned ub = b & m;
        int unsigned x;
        int unsigned s;
        int d;
        bit c = 0, v = 0, z, n, sa, sb, sr, sg;
        logic [15:0] r, full;
        int fw;
        case (op)
            0, 1: begin
                s = ua + ub + ((op == 1) ? ci : 0);
                x = s & m;
                c = (s >> w) & 1;
                sa = (ua >> (w-1)) & 1; sb = (ub >> (w-1)) & 1; sr = (x >> (w-1)) & 1;
                v = (sa == sb) && (sr != sa);
            end
            2, 3: begin
                d = int'(ua) - int'(ub) - ((op == 3) ? int'(ci) : 0);
                c = (d < 0);
                x = d & m;
                sa = (ua >> (w-1)) & 1; sb = (ub >> (w-1)) & 1; sr = (x >> (w-1)) & 1;
                v = (sa != sb) && (sr != sa);
            end
            4: x = ua & ub;
            5: x = ua | ub;
            6: x = ua ^ ub;
            7: x = {{8{a[7]}}, a[7:0]};
            default: begin
                x = ua;
                sg = (ua >> (w-1)) & 1;
                for (int i = 0; i < int'(b[3:0]); i++) begin
                    case (op)
                        8:  begin c = (x >> (w-1)) & 1; x = (x << 1) & m; end
                        9:  begin c = x & 1; x = x >> 1; end
                        10: begin c = x & 1; x = (x >> 1) | (int'(sg) << (w-1)); end
                        11: begin c = (x >> (w-1)) & 1; x = ((x << 1) | c) & m; end
                        default: begin c = x & 1; x = (x >> 1) | (int'(c) << (w-1)); end
                    endcase
                end
            end
        endcase
        r = x[15:0];
        if (op == 7) begin
            full = r; fw = 16;
        end else begin
            full = bm ? {a[15:8], r[7:0]} : r; fw = w;
        end
        z = (fw == 8) ? (full[7:0] == 0) : (full == 0);
        n = (fw == 8) ? full[7] : full[15];
        return {full, z, n, c, v};
    endfunction

    task automatic check(string tag, logic [15:0] act_r, logic [3:0] act_f,
                         logic [15:0] exp_r, logic [3:0] exp_f);
        total++;
        if (act_r !== exp_r) begin
            bad++;
            $display("FAIL %s result act=%h exp=%h", tag, act_r, exp_r);
        end
        total++;
        if (act_f !== exp_f) begin
            bad++;
            $display("FAIL %s flags(znvc as zncv) act=%b exp=%b", tag, act_f, exp_f);
        end
    endtask

    // Issue one operation and check it one cycle later (R12).
    task automatic run_op(string tag, int op, bit bm, bit ci,
                          logic [15:0] a, logic [15:0] b);
        logic [19:0] e;
        @(negedge clk);
        op_code = op[3:0]; byte_mode = bm; carry_in = ci;
        opnd_a = a; opnd_b = b; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        e = model(op, bm, ci, a, b);
        check(tag, result, {flag_z, flag_n, flag_c, flag_v}, e[19:4], e[3:0]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", result, {flag_z, flag_n, flag_c, flag_v}, 16'h0, 4'b0000);
        rst = 1'b0;
    endtask

    task automatic t_add_word();
        run_op("R2 add", 0, 0, 1, 16'h1234, 16'h4321);
        run_op("R2 add carry out", 0, 0, 1, 16'hFFFF, 16'h0001);
        run_op("R2 addc", 1, 0, 1, 16'h00FF, 16'h0100);
        run_op("R4 add ovf", 0, 0, 0, 16'h7FFF, 16'h0001);
        run_op("R4 add neg ovf", 1, 0, 0, 16'h8000, 16'h8000);
    endtask

    task automatic t_sub_word();
        run_op("R3 sub", 2, 0, 1, 16'h5000, 16'h1000);
        run_op("R3 sub borrow", 2, 0, 0, 16'h0001, 16'h0002);
        run_op("R3 subc", 3, 0, 1, 16'h0005, 16'h0005);
        run_op("R4 sub ovf", 2, 0, 0, 16'h8000, 16'h0001);
    endtask

    task automatic t_multiword();
        logic [31:0] x = 32'h89AB_FFFF, y = 32'h1234_0001;
        logic [31:0] s;
        bit c;
        // 32-bit add: low with ADD, high with ADDC fed from the carry flag.
        run_op("R2 chain lo", 0, 0, 0, x[15:0], y[15:0]);
        s[15:0] = result; c = flag_c;
        run_op("R2 chain hi", 1, 0, c, x[31:16], y[31:16]);
        s[31:16] = result;
        total++;
        if (s !== x + y) begin
            bad++; $display("FAIL R2 32-bit sum act=%h exp=%h", s, x + y);
        end
        // 32-bit subtract with borrow chaining.
        run_op("R3 chain lo", 2, 0, 0, y[15:0], x[15:0]);
        s[15:0] = result; c = flag_c;
        run_op("R3 chain hi", 3, 0, c, y[31:16], x[31:16]);
        s[31:16] = result;
        total++;
        if (s !== y - x) begin
            bad++; $display("FAIL R3 32-bit diff act=%h exp=%h", s, y - x);
        end
    endtask

    task automatic t_byte_arith();
        run_op("R5 byte add", 0, 1, 0, 16'hA5FF, 16'h3C01);
        run_op("R5 byte ovf bit6", 0, 1, 0, 16'h807F, 16'h7F01);
        run_op("R5 byte addc", 1, 1, 1, 16'h1280, 16'hFF80);
        run_op("R5 byte sub borrow", 2, 1, 0, 16'h7F00, 16'h0001);
        run_op("R5 byte subc", 3, 1, 1, 16'hC380, 16'h0000);
        run_op("R5 byte zero low", 4, 1, 0, 16'hFF0F, 16'hFFF0);
    endtask

    task automatic t_logic();
        run_op("R6 and", 4, 0, 1, 16'hF0F0, 16'hFF00);
        run_op("R6 or", 5, 0, 1, 16'h0F00, 16'h8001);
        run_op("R6 xor zero", 6, 0, 1, 16'h5A5A, 16'h5A5A);
        run_op("R6 byte xor", 6, 1, 1, 16'h1234, 16'hFFFF);
    endtask

    task automatic t_sext();
        run_op("R7 sext neg", 7, 0, 1, 16'h1280, 16'h0);
        run_op("R7 sext pos byte mode", 7, 1, 1, 16'hFF7F, 16'h0);
        run_op("R7 sext zero", 7, 1, 0, 16'hAB00, 16'h0);
    endtask

    task automatic t_shifts();
        logic [15:0] pats [3] = '{16'hB3C1, 16'h8001, 16'h4E96};
        for (int p = 0; p < 3; p++) begin
            for (int bm = 0; bm < 2; bm++) begin
                for (int op = 8; op <= 12; op++) begin
                    for (int n = 0; n < 16; n++) begin
                        string tag;
                        if (n == 0) tag = "R10 zero count";
                        else if (op >= 11) tag = "R9 rotate";
                        else tag = "R8 shift";
                        run_op(tag, op, bm[0], 1'b1, pats[p], {12'hABC, n[3:0]});
                    end
                end
            end
        end
    endtask

    task automatic t_hold();
        logic [15:0] r0;
        logic [3:0]  f0;
        run_op("R11 setup", 2, 0, 0, 16'h0001, 16'h0002);
        r0 = result; f0 = {flag_z, flag_n, flag_c, flag_v};
        @(negedge clk);
        op_code = 4'd0; opnd_a = 16'h0000; opnd_b = 16'h0000; op_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 idle hold", result, {flag_z, flag_n, flag_c, flag_v}, r0, f0);
        for (int op = 13; op < 16; op++) begin
            op_code = op[3:0]; opnd_a = 16'h0; opnd_b = 16'h0; op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            check("R11 reserved op", result, {flag_z, flag_n, flag_c, flag_v}, r0, f0);
        end
    endtask

    task automatic t_back_to_back();
        logic [19:0] e;
        @(negedge clk);
        op_code = 4'd0; byte_mode = 0; opnd_a = 16'h0100; opnd_b = 16'h0200; op_valid = 1;
        @(negedge clk);
        e = model(0, 0, 0, 16'h0100, 16'h0200);
        check("R12 first of pair", result, {flag_z, flag_n, flag_c, flag_v}, e[19:4], e[3:0]);
        op_code = 4'd6; opnd_a = 16'hFFFF; opnd_b = 16'h00FF;
        @(negedge clk);
        op_valid = 0;
        e = model(6, 0, 0, 16'hFFFF, 16'h00FF);
        check("R12 second of pair", result, {flag_z, flag_n, flag_c, flag_v}, e[19:4], e[3:0]);
    endtask

    initial begin
        t_reset();
        t_add_word();
        t_sub_word();
        t_multiword();
        t_byte_arith();
        t_logic();
        t_sext();
        t_shifts();
        t_hold();
        t_back_to_back();
        run_op("R1 pre-reset op", 0, 0, 0, 16'h8000, 16'h8000);
        t_reset();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule